// File: doc/BRIEF.md
# Write-Back Store Buffer with Pairwise-Age Replacement

This block sits between a processor's operand path and main memory and holds the most recent operand stores in eight fully associative slots. Each slot holds a 48-bit word and a 16-bit address tag. Loads that match a tag are answered from the slot. Loads that miss are reported back so that the requester reads memory itself, and they allocate nothing. Recency is kept as a triangular matrix of pairwise "newer than" bits, and a registered pointer names the oldest slot.

A store that misses takes the oldest slot. A store that overwrites the oldest slot, whether as a miss or as a match, causes the slot that becomes oldest to be written back to memory through a valid/ready write port, and its tag is cleared. In steady state one slot is therefore always empty and ready for the next miss. Bit 15 of an address marks it as unmapped. Mapped victims get their physical page frame from a lookup port while the write is pending. Stores to unmapped addresses 1 to 7 (the switch-register window) store nothing. Instead they step a drain sequence that empties the buffer one slot per store.

Top module: `wb_store_buffer`

## Requirements
- R1: After reset `req_ready` is 1, `mw_valid` and `rsp_valid` are 0, and every load misses.
- R2: A store whose address equals a held tag replaces that slot's word. A later load of that address returns the new word, and when the slot was not the oldest, no memory write occurs.
- R3: A store that matches no tag takes the current oldest slot. Every slot that a store writes becomes the newest.
- R4: When a store writes the oldest slot, the slot that is then oldest is written back and its tag is cleared. A later load of the written-back address misses.
- R5: Writing back a slot whose tag is zero (empty) produces no memory write.
- R6: A load that hits returns the slot's word with `rsp_hit` = 1. When the slot is not the oldest, the load marks it newest, and this changes the order of later write-backs.
- R7: A load miss returns `rsp_hit` = 0 with data 0. It writes nothing to memory and does not change slot contents or age order.
- R8: A request whose address bits 14:0 are all zero is ignored. A store of this kind changes nothing, including the drain step. A load of this kind returns `rsp_hit` = 1 with data 0.
- R9: The write-back address is tag bits 14:0 when tag bit 15 is 1. Otherwise it is {`pg_frame`, tag bits 9:0}, where `pg_vpage` presents tag bits 14:10.
- R10: A store with bit 15 = 1 and bits 14:0 in 1..7 stores nothing and advances a drain step. Step 0 does nothing. Steps 1 to 8 each mark the oldest slot newest and then write back the slot that becomes oldest. Steps 9 and beyond do nothing.
- R11: On drain step 7, after the write-back, the age matrix clears. Slot 0 becomes the oldest, and the age order becomes the slot index order.
- R12: Any other store (not in the drain window and not ignored) resets the drain step to 0.
- R13: `mw_valid` stays high with a stable address and word until `mw_ready`. While `mw_valid` is high, `req_ready` is 0.
- R14: `rsp_valid` pulses exactly one cycle after each accepted load and never otherwise. A write-back raises `mw_valid` one cycle after the store that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Address; bit 15 = unmapped |
| req_wdata | input | 48 | Store word |
| rsp_valid | output | 1 | Load response strobe |
| rsp_hit | output | 1 | Load served by the buffer |
| rsp_data | output | 48 | Load word (0 on miss) |
| pg_vpage | output | 5 | Virtual page of pending write-back |
| pg_frame | input | 5 | Page frame for `pg_vpage` |
| mw_valid | output | 1 | Memory write pending |
| mw_ready | input | 1 | Memory accepts write |
| mw_addr | output | 15 | Physical write address |
| mw_data | output | 48 | Write word |

## Verification
The bench aims at the write-back choice that follows each store. If the design evicted the slot it had just written, instead of the next-oldest one, the wrong address would appear on the write port or the write would vanish. A load hit that failed to refresh recency would show up as a later write-back of the wrong slot. In the drain sequence, a design that acted on step 0, missed the clear at step 7 or did not saturate would emit extra or misordered writes. Held-low `mw_ready`, unmapped victims and ignored zero addresses are probed for unstable writes, wrong frame joins and spurious allocation.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  // Bit position of the pair (n,m), n<m, in a triangular matrix of 'ents' entries.
  function automatic int pair_bit(input int n, input int m, input int ents);
    return (n * (2 * ents - n - 1)) / 2 + (m - n - 1);
  endfunction

endpackage

// File: rtl/wsb_age_matrix.sv
module wsb_age_matrix #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             promote_en,
  input  logic [IDX_W-1:0] promote_idx,
  input  logic             recompute,
  input  logic             clear_all,
  output logic [IDX_W-1:0] oldest_q,
  output logic [IDX_W-1:0] victim_idx
);
  import wsb_pkg::*;

  localparam int PAIRS = ENTRIES * (ENTRIES - 1) / 2;
  typedef logic [PAIRS-1:0] pv_t;

  function automatic pv_t row_mask(input int i);
    pv_t r = '0;
    for (int m = i + 1; m < ENTRIES; m++) r = r | (pv_t'(1) << pair_bit(i, m, ENTRIES));
    return r;
  endfunction

  function automatic pv_t col_mask(input int i);
    pv_t r = '0;
    for (int n = 0; n < i; n++) r = r | (pv_t'(1) << pair_bit(n, i, ENTRIES));
    return r;
  endfunction

  pv_t mat_q, mat_nx;
  pv_t newer_m [ENTRIES];
  pv_t older_m [ENTRIES];
  logic [ENTRIES-1:0] is_oldest;
  logic               found;
  logic [IDX_W-1:0]   cand;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_mask
    localparam pv_t ROW = row_mask(g);
    localparam pv_t COL = col_mask(g);
    assign newer_m[g]   = ROW;
    assign older_m[g]   = COL;
    assign is_oldest[g] = ((mat_nx & ROW) == '0) && ((mat_nx & COL) == COL);
  end

  always_comb begin
    mat_nx = mat_q;
    if (promote_en)
      mat_nx = (mat_q & ~older_m[promote_idx]) | newer_m[promote_idx];
  end

  always_comb begin
    found = 1'b0;
    cand  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (is_oldest[i]) begin
        found = 1'b1;
        cand  = IDX_W'(i);
      end
    end
  end

  assign victim_idx = found ? cand : oldest_q;

  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      mat_q    <= '0;
      oldest_q <= '0;
    end else begin
      mat_q <= mat_nx;
      if (recompute && found) oldest_q <= cand;
    end
  end

endmodule

// File: rtl/wsb_tag_match.sv
module wsb_tag_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ADDR_W-1:0] tags [ENTRIES],
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = (tags[g] == addr) && (tags[g] != '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/wsb_evict_port.sv
module wsb_evict_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 48,
  parameter int OFFS_W = 10,
  localparam int PHYS_W  = ADDR_W - 1,
  localparam int FRAME_W = PHYS_W - OFFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue,
  input  logic [ADDR_W-1:0]  issue_tag,
  input  logic [DATA_W-1:0]  issue_data,
  output logic [FRAME_W-1:0] pg_vpage,
  input  logic [FRAME_W-1:0] pg_frame,
  output logic               mw_valid,
  input  logic               mw_ready,
  output logic [PHYS_W-1:0]  mw_addr,
  output logic [DATA_W-1:0]  mw_data
);
  logic [ADDR_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_valid <= 1'b0;
      tag_q    <= '0;
      mw_data  <= '0;
    end else if (issue) begin
      mw_valid <= 1'b1;
      tag_q    <= issue_tag;
      mw_data  <= issue_data;
    end else if (mw_ready) begin
      mw_valid <= 1'b0;
    end
  end

  assign pg_vpage = tag_q[PHYS_W-1:OFFS_W];
  assign mw_addr  = tag_q[ADDR_W-1] ? tag_q[PHYS_W-1:0] : {pg_frame, tag_q[OFFS_W-1:0]};

endmodule

// File: rtl/wb_store_buffer.sv
module wb_store_buffer #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 48,
  parameter int OFFS_W  = 10,
  parameter int SW_LAST = 7,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int PHYS_W  = ADDR_W - 1,
  localparam int FRAME_W = PHYS_W - OFFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_store,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [FRAME_W-1:0] pg_vpage,
  input  logic [FRAME_W-1:0] pg_frame,
  output logic               mw_valid,
  input  logic               mw_ready,
  output logic [PHYS_W-1:0]  mw_addr,
  output logic [DATA_W-1:0]  mw_data
);
  localparam int CNT_W = $clog2(ENTRIES + 2);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] STEP_CLR  = CNT_W'(ENTRIES - 1);
  localparam logic [CNT_W-1:0] STEP_SAT  = CNT_W'(ENTRIES + 1);
  localparam logic [PHYS_W-1:0] SW_TOP   = PHYS_W'(SW_LAST);

  logic [ADDR_W-1:0] tags_q [ENTRIES];
  logic [DATA_W-1:0] data_q [ENTRIES];
  logic [CNT_W-1:0]  step_q, step_nx;

  logic             fire, ld_fire, null_addr, sw_addr;
  logic             hit;
  logic [IDX_W-1:0] hit_idx, oldest, victim, wr_idx, promote_idx;
  logic             promote_en, recompute, clear_all, wr_en, evict_req, issue;

  assign req_ready = !mw_valid;
  assign fire      = req_valid && req_ready;
  assign ld_fire   = fire && !req_store;
  assign null_addr = (req_addr[PHYS_W-1:0] == '0);
  assign sw_addr   = req_addr[ADDR_W-1] && !null_addr && (req_addr[PHYS_W-1:0] <= SW_TOP);

  wsb_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .tags    (tags_q),
    .addr    (req_addr),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  wsb_age_matrix #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_age (
    .clk         (clk),
    .rst         (rst),
    .promote_en  (promote_en),
    .promote_idx (promote_idx),
    .recompute   (recompute),
    .clear_all   (clear_all),
    .oldest_q    (oldest),
    .victim_idx  (victim)
  );

  always_comb begin
    promote_en  = 1'b0;
    promote_idx = oldest;
    recompute   = 1'b0;
    clear_all   = 1'b0;
    wr_en       = 1'b0;
    wr_idx      = hit ? hit_idx : oldest;
    evict_req   = 1'b0;
    step_nx     = step_q;
    if (fire && req_store && !null_addr) begin
      if (sw_addr) begin
        if (step_q != '0 && step_q <= STEP_LAST) begin
          promote_en = 1'b1;
          recompute  = 1'b1;
          evict_req  = 1'b1;
          clear_all  = (step_q == STEP_CLR);
        end
        if (step_q != STEP_SAT) step_nx = step_q + 1'b1;
      end else begin
        step_nx     = '0;
        wr_en       = 1'b1;
        promote_en  = 1'b1;
        promote_idx = wr_idx;
        recompute   = (wr_idx == oldest);
        evict_req   = recompute;
      end
    end else if (ld_fire && !null_addr && hit && hit_idx != oldest) begin
      promote_en  = 1'b1;
      promote_idx = hit_idx;
    end
  end

  assign issue = evict_req && (tags_q[victim] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      for (int i = 0; i < ENTRIES; i++) tags_q[i] <= '0;
    end else begin
      step_q <= step_nx;
      if (evict_req) tags_q[victim] <= '0;
      if (wr_en)     tags_q[wr_idx] <= req_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= ld_fire;
      if (ld_fire) begin
        rsp_hit  <= null_addr || hit;
        rsp_data <= (hit && !null_addr) ? data_q[hit_idx] : '0;
      end
    end
  end

  wsb_evict_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_evict (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_tag  (tags_q[victim]),
    .issue_data (data_q[victim]),
    .pg_vpage   (pg_vpage),
    .pg_frame   (pg_frame),
    .mw_valid   (mw_valid),
    .mw_ready   (mw_ready),
    .mw_addr    (mw_addr),
    .mw_data    (mw_data)
  );

endmodule

// File: rtl/wb_store_buffer_chk.sv
module wb_store_buffer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 48,
  parameter int PHYS_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_store,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [PHYS_W-1:0] mw_addr,
  input logic [DATA_W-1:0] mw_data
);
  logic acc_ld, acc_st, nul;
  assign acc_ld = req_valid && req_ready && !req_store;
  assign acc_st = req_valid && req_ready && req_store;
  assign nul    = (req_addr[ADDR_W-2:0] == '0);

  AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    acc_ld |=> rsp_valid); // R14
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    !acc_ld |=> !rsp_valid); // R14
  AST_NULL_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    acc_ld && nul |=> rsp_hit && (rsp_data == '0)); // R8
  AST_NULL_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    acc_st && nul |=> !mw_valid); // R8
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    acc_ld |=> !mw_valid); // R7
  AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> (rsp_data == '0)); // R7
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data)); // R13

endmodule

bind wb_store_buffer wb_store_buffer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .PHYS_W (ADDR_W - 1)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_store (req_store),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_data  (rsp_data),
  .mw_valid  (mw_valid),
  .mw_ready  (mw_ready),
  .mw_addr   (mw_addr),
  .mw_data   (mw_data)
);

// File: tb/wb_store_buffer_tb.sv
`timescale 1ns/1ps
module wb_store_buffer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [15:0] req_addr = '0;
  logic [47:0] req_wdata = '0;
  logic        rsp_valid, rsp_hit;
  logic [47:0] rsp_data;
  logic [4:0]  pg_vpage, pg_frame;
  logic        mw_valid;
  logic        mw_ready = 1'b0;
  logic [14:0] mw_addr;
  logic [47:0] mw_data;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;
  assign pg_frame = pg_vpage ^ 5'h16;

  wb_store_buffer u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .pg_vpage(pg_vpage), .pg_frame(pg_frame), .mw_valid(mw_valid),
    .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
  );

  // reference model: recency list, order[0] oldest
  logic [15:0] m_tag [8];
  logic [47:0] m_data [8];
  int          order [8];
  int          m_step;
  logic [15:0] last_ev;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [14:0] phys(input logic [15:0] t);
    return t[15] ? t[14:0] : {t[14:10] ^ 5'h16, t[9:0]};
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin m_tag[i] = '0; m_data[i] = '0; order[i] = i; end
    m_step = 0;
  endtask

  task automatic m_promote(input int idx);
    int p = 0;
    for (int i = 0; i < 8; i++) if (order[i] == idx) p = i;
    for (int i = p; i < 7; i++) order[i] = order[i+1];
    order[7] = idx;
  endtask

  task automatic m_evict(output bit ev, output logic [14:0] ea, output logic [47:0] ed);
    int v = order[0];
    ev = (m_tag[v] != '0);
    ea = phys(m_tag[v]);
    ed = m_data[v];
    if (ev) last_ev = m_tag[v];
    m_tag[v] = '0;
  endtask

  task automatic m_store(input logic [15:0] a, input logic [47:0] d,
                         output bit ev, output logic [14:0] ea, output logic [47:0] ed);
    int idx;
    bit was_old;
    ev = 0; ea = '0; ed = '0;
    if (a[14:0] == '0) return;
    if (a[15] && a[14:0] <= 15'd7) begin
      if (m_step >= 1 && m_step <= 8) begin
        m_promote(order[0]);
        m_evict(ev, ea, ed);
        if (m_step == 7) for (int i = 0; i < 8; i++) order[i] = i;
      end
      if (m_step < 9) m_step++;
      return;
    end
    m_step = 0;
    idx = order[0];
    for (int i = 0; i < 8; i++) if (m_tag[i] == a) idx = i;
    was_old = (idx == order[0]);
    m_tag[idx] = a; m_data[idx] = d;
    m_promote(idx);
    if (was_old) m_evict(ev, ea, ed);
  endtask

  task automatic m_load(input logic [15:0] a, output bit h, output logic [47:0] d);
    h = 0; d = '0;
    if (a[14:0] == '0) begin h = 1; return; end
    for (int i = 0; i < 8; i++) begin
      if (m_tag[i] == a) begin
        h = 1; d = m_data[i];
        if (i != order[0]) m_promote(i);
      end
    end
  endtask

  task automatic do_store(input logic [15:0] a, input logic [47:0] d, input int lat, input string r);
    bit ev; logic [14:0] ea; logic [47:0] ed;
    m_store(a, d, ev, ea, ed);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk({r, " write strobe"}, 64'(mw_valid), 64'(ev));
    if (ev) begin
      chk({r, " write addr"}, 64'(mw_addr), 64'(ea));
      chk({r, " write data"}, 64'(mw_data), 64'(ed));
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk("R13 hold", {mw_valid, req_ready, 15'(mw_addr)}, {1'b1, 1'b0, ea});
      end
      mw_ready = 1;
      @(negedge clk);
      mw_ready = 0;
      chk("R13 release", {mw_valid, req_ready}, 2'b01);
    end
  endtask

  task automatic do_load(input logic [15:0] a, input string r);
    bit h; logic [47:0] d;
    m_load(a, h, d);
    @(negedge clk);
    req_valid = 1; req_store = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk({r, " R14 rsp"}, 64'(rsp_valid), 64'd1);
    chk({r, " hit"}, 64'(rsp_hit), 64'(h));
    chk({r, " data"}, rsp_data, d);
    @(negedge clk);
    chk("R14 single pulse", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 no write", 64'(mw_valid), 64'd0);
    chk("R1 no rsp", 64'(rsp_valid), 64'd0);
    do_load(16'h0405, "R1 miss");
  endtask

  task automatic t_fill();
    logic [15:0] ad [7] = '{16'h0401, 16'h0802, 16'h8100, 16'h0C03, 16'h1404, 16'h8200, 16'h2005};
    for (int k = 0; k < 7; k++) do_store(ad[k], 48'hA00000 + 48'(k), 0, "R5");
    for (int k = 0; k < 7; k++) do_load(ad[k], "R6");
    do_load(16'h7777, "R7 miss");
    do_store(16'h3006, 48'hB1, 2, "R3");
    do_load(last_ev, "R4 evicted misses");
    do_load(16'h0C03, "R6 promote");
    do_store(16'h3407, 48'hB2, 0, "R6");
    do_store(16'h3808, 48'hB3, 1, "R9");
  endtask

  task automatic t_overwrite();
    do_store(16'h1404, 48'hC0FFEE, 0, "R2");
    do_load(16'h1404, "R2");
  endtask

  task automatic t_mixed();
    for (int k = 0; k < 8; k++) begin
      do_store(16'h8300 + 16'(k), 48'hD00 + 48'(k), k % 3, "R9");
      do_store(16'h4400 + 16'(k), 48'hE00 + 48'(k), 1, "R9");
    end
  endtask

  task automatic t_null();
    do_store(16'h0000, 48'h1234, 0, "R8");
    do_store(16'h8000, 48'h5678, 0, "R8");
    do_load(16'h0000, "R8");
    do_load(16'h8000, "R8");
    do_store(16'h5009, 48'hF1, 0, "R8 no slot used");
  endtask

  task automatic t_drain();
    for (int k = 0; k < 5; k++) do_store(16'h6000 + 16'(k), 48'h900 + 48'(k), 0, "R3");
    for (int k = 0; k < 10; k++) do_store(16'h8001 + 16'(k % 7), 48'hDEAD, 1, "R10");
    do_store(16'h6100, 48'h77, 0, "R11");
    do_store(16'h6101, 48'h78, 0, "R11");
    do_store(16'h8004, 48'h0, 0, "R12 step0");
    do_store(16'h8005, 48'h0, 0, "R10");
    do_store(16'h6102, 48'h79, 0, "R12");
    do_store(16'h8006, 48'h0, 0, "R12 step0");
    do_load(16'h6100, "R11");
  endtask

  initial begin
    #(4 * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    m_reset();
    last_ev = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_overwrite();
    t_mixed();
    t_null();
    t_drain();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule